// File: doc/BRIEF.md
# Branch Condition Code Evaluator

This block decides whether a conditional branch is taken. It receives the leading opcode byte, the byte that follows it, the five arithmetic flags (carry, zero, sign, overflow, parity), the count register and an address-width flag. It drives a `cond_valid` output and a `take_branch` output with no clock.

`cond_valid` is high when the bytes form a recognised conditional branch. `take_branch` is high when that branch is taken. An instruction decoder feeds the block and a fetch unit uses its result to choose the next address. Computing the target and updating the flags are done elsewhere.

The block sorts every input into one of four opcode classes:

- `CLS_NONE`: not a conditional branch.
- `CLS_SHORT`: a single-byte flag branch.
- `CLS_NEAR`: the escape byte followed by a flag branch.
- `CLS_COUNT`: the count-register-zero test.

The classification is a `unique case` selection over these classes. For the two flag classes, a 4-bit condition code indexes a bank of sixteen flag predicates. Bit 0 of the code turns each predicate into its negation. For `CLS_COUNT`, a zero detector on the count register decides instead.

Top module: `brcc_eval`

## Requirements
- R1: A lead byte outside 70h..7Fh and other than E3h gives `cond_valid`=0 and `take_branch`=0. This includes 0Fh when the following byte lies outside 80h..8Fh.
- R2: For every flag branch, the opcodes 2k and 2k+1 (codes that differ only in bit 0) give opposite `take_branch` values for the same flags.
- R3: Codes 0h/1h take the branch on OF=1/OF=0. Codes 2h/3h take it on CF=1/CF=0. Codes 4h/5h take it on ZF=1/ZF=0.
- R4: Code 6h takes the branch when CF=1 or ZF=1. Code 7h takes it when CF=0 and ZF=0.
- R5: Codes 8h/9h take the branch on SF=1/SF=0. Codes Ah/Bh take it on PF=1/PF=0.
- R6: Code Ch takes the branch when SF≠OF, and code Dh when SF=OF. Code Eh takes it when ZF=1 or SF≠OF. Code Fh takes it when ZF=0 and SF=OF.
- R7: Lead byte 0Fh followed by 8xh gives `cond_valid`=1 and evaluates condition code x exactly as the short form 7xh does.
- R8: For a lead byte 7xh, the following byte has no effect on either output.
- R9: Lead byte E3h with `addr_wide`=0 gives `cond_valid`=1. It takes the branch exactly when bits 15:0 of the count are zero; bits 31:16 are ignored.
- R10: Lead byte E3h with `addr_wide`=1 takes the branch exactly when all 32 count bits are zero.
- R11: For lead byte E3h, the flag inputs have no effect on `take_branch`.
- R12: `take_branch` is never high while `cond_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_lead | input | 8 | First opcode byte |
| op_ext | input | 8 | Byte after the first; used only after the 0Fh escape |
| flag_cf | input | 1 | Carry flag |
| flag_zf | input | 1 | Zero flag |
| flag_sf | input | 1 | Sign flag |
| flag_of | input | 1 | Overflow flag |
| flag_pf | input | 1 | Parity flag |
| count_val | input | 32 | Count register contents |
| addr_wide | input | 1 | 1: 32-bit address size, 0: 16-bit |
| cond_valid | output | 1 | Recognised conditional branch opcode |
| take_branch | output | 1 | Branch condition holds |

## Verification
The bench drives every flag-branch code in both encodings with all 32 flag combinations. This catches a swapped predicate, a missing inversion on bit 0, or an escape form that reads the lead byte's nibble and so evaluates the wrong condition. A count of exactly 10000h is the key case for the zero test. A design that ignores `addr_wide` either fails to branch in 16-bit mode or wrongly branches in 32-bit mode. The bench also holds the count fixed while changing the flags, which exposes a design that lets a flag leak into the count test. Every lead byte, and the escape byte with every following byte, is swept to find a decoder that accepts a neighbouring opcode such as 6Fh, 80h, E2h or 0F 90h.

// File: rtl/brcc_pkg.sv
package brcc_pkg;

    localparam int BYTE_W  = 8;
    localparam int CODE_W  = 4;
    localparam int N_CODES = 1 << CODE_W;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_SHORT = 2'd1,
        CLS_NEAR  = 2'd2,
        CLS_COUNT = 2'd3
    } op_class_e;

    typedef struct packed {
        logic cf;
        logic zf;
        logic sf;
        logic of;
        logic pf;
    } flag_set_t;

    // Predicate for one condition code; each code is written out on its own.
    function automatic logic eval_code(input logic [CODE_W-1:0] code, input flag_set_t f);
        logic r;
        unique case (code)
            4'h0: r = f.of;
            4'h1: r = ~f.of;
            4'h2: r = f.cf;
            4'h3: r = ~f.cf;
            4'h4: r = f.zf;
            4'h5: r = ~f.zf;
            4'h6: r = f.cf | f.zf;
            4'h7: r = ~f.cf & ~f.zf;
            4'h8: r = f.sf;
            4'h9: r = ~f.sf;
            4'hA: r = f.pf;
            4'hB: r = ~f.pf;
            4'hC: r = f.sf ^ f.of;
            4'hD: r = ~(f.sf ^ f.of);
            4'hE: r = f.zf | (f.sf ^ f.of);
            4'hF: r = ~f.zf & ~(f.sf ^ f.of);
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/brcc_classify.sv
module brcc_classify
    import brcc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ESCAPE_OP  = 8'h0F,
    parameter logic [BYTE_W-1:0] COUNT_OP   = 8'hE3,
    parameter logic [BYTE_W-CODE_W-1:0] SHORT_ROW = 4'h7,
    parameter logic [BYTE_W-CODE_W-1:0] NEAR_ROW  = 4'h8
) (
    input  logic [BYTE_W-1:0] op_lead,
    input  logic [BYTE_W-1:0] op_ext,
    output op_class_e         op_class,
    output logic [CODE_W-1:0] cond_code
);

    localparam int ROW_HI = BYTE_W - 1;
    localparam int ROW_LO = CODE_W;

    always_comb begin
        op_class  = CLS_NONE;
        cond_code = '0;
        if (op_lead[ROW_HI:ROW_LO] == SHORT_ROW) begin
            op_class  = CLS_SHORT;
            cond_code = op_lead[CODE_W-1:0];
        end else if (op_lead == ESCAPE_OP && op_ext[ROW_HI:ROW_LO] == NEAR_ROW) begin
            op_class  = CLS_NEAR;
            cond_code = op_ext[CODE_W-1:0];
        end else if (op_lead == COUNT_OP) begin
            op_class  = CLS_COUNT;
        end
    end

    // R8: a short-form lead byte always picks its own low nibble
    always_comb begin
        p_short_own_code_r8: assert (op_lead[ROW_HI:ROW_LO] != SHORT_ROW ||
                                     (op_class == CLS_SHORT && cond_code == op_lead[CODE_W-1:0]))
            else $error("R8 short form decoded from wrong byte");
    end

endmodule

// File: rtl/brcc_pred_bank.sv
module brcc_pred_bank
    import brcc_pkg::*;
(
    input  flag_set_t           flags,
    output logic [N_CODES-1:0]  pred
);

    localparam int N_PAIRS = N_CODES / 2;

    for (genvar i = 0; i < N_CODES; i++) begin : g_pred
        assign pred[i] = eval_code(CODE_W'(i), flags);
    end

    // R2: each pair of neighbouring codes is mutually exclusive and complete
    for (genvar k = 0; k < N_PAIRS; k++) begin : g_pair_chk
        always_comb begin
            p_pair_inverse_r2: assert (pred[2*k] != pred[2*k+1])
                else $error("R2 pair %0d not complementary", k);
        end
    end

    always_comb begin
        // R4: unsigned below-or-equal is carry or zero
        p_below_eq_r4: assert (pred[6] == (pred[2] | pred[4]))
            else $error("R4 below-or-equal inconsistent");
        // R6: signed less-or-equal is zero or less
        p_less_eq_r6: assert (pred[14] == (pred[4] | pred[12]))
            else $error("R6 less-or-equal inconsistent");
    end

endmodule

// File: rtl/brcc_count_zero.sv
module brcc_count_zero #(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16
) (
    input  logic [CNT_W-1:0] count_val,
    input  logic             addr_wide,
    output logic             is_zero
);

    logic lo_zero;
    logic hi_zero;

    assign lo_zero = ~|count_val[NARROW_W-1:0];
    assign hi_zero = ~|count_val[CNT_W-1:NARROW_W];
    assign is_zero = lo_zero & (hi_zero | ~addr_wide);

    always_comb begin
        // R10: in wide mode a zero verdict means the whole register is empty
        p_wide_full_r10: assert (!(addr_wide && is_zero) || count_val == '0)
            else $error("R10 wide zero with nonzero count");
        // R9: in narrow mode the upper half never blocks the verdict
        p_narrow_upper_r9: assert (addr_wide || is_zero == (count_val[NARROW_W-1:0] == '0))
            else $error("R9 narrow verdict wrong");
    end

endmodule

// File: rtl/brcc_eval.sv
module brcc_eval
    import brcc_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16
) (
    input  logic [7:0]       op_lead,
    input  logic [7:0]       op_ext,
    input  logic             flag_cf,
    input  logic             flag_zf,
    input  logic             flag_sf,
    input  logic             flag_of,
    input  logic             flag_pf,
    input  logic [CNT_W-1:0] count_val,
    input  logic             addr_wide,
    output logic             cond_valid,
    output logic             take_branch
);

    op_class_e           op_class;
    logic [CODE_W-1:0]   cond_code;
    logic [N_CODES-1:0]  pred;
    logic                cnt_zero;
    flag_set_t           flags;

    assign flags = '{cf: flag_cf, zf: flag_zf, sf: flag_sf, of: flag_of, pf: flag_pf};

    brcc_classify u_classify (
        .op_lead   (op_lead),
        .op_ext    (op_ext),
        .op_class  (op_class),
        .cond_code (cond_code)
    );

    brcc_pred_bank u_pred (
        .flags (flags),
        .pred  (pred)
    );

    brcc_count_zero #(
        .CNT_W    (CNT_W),
        .NARROW_W (NARROW_W)
    ) u_cnt (
        .count_val (count_val),
        .addr_wide (addr_wide),
        .is_zero   (cnt_zero)
    );

    always_comb begin
        cond_valid  = 1'b0;
        take_branch = 1'b0;
        unique case (op_class)
            CLS_NONE: begin
                cond_valid  = 1'b0;
                take_branch = 1'b0;
            end
            CLS_SHORT, CLS_NEAR: begin
                cond_valid  = 1'b1;
                take_branch = pred[cond_code];
            end
            CLS_COUNT: begin
                cond_valid  = 1'b1;
                take_branch = cnt_zero;
            end
            default: begin
                cond_valid  = 1'b0;
                take_branch = 1'b0;
            end
        endcase
    end

    always_comb begin
        // R12: a taken branch is always a recognised one
        p_take_needs_valid_r12: assert (!take_branch || cond_valid)
            else $error("R12 take without valid");
        // R1: an unrecognised lead byte never validates
        p_unknown_lead_r1: assert (op_lead == 8'h0F || op_lead == 8'hE3 ||
                                   op_lead[7:4] == 4'h7 || !cond_valid)
            else $error("R1 unknown lead validated");
    end

endmodule

// File: tb/brcc_eval_bench.sv
`timescale 1ns/1ps
module brcc_eval_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  op_lead = 8'h00;
    logic [7:0]  op_ext = 8'h00;
    logic        flag_cf = 0, flag_zf = 0, flag_sf = 0, flag_of = 0, flag_pf = 0;
    logic [31:0] count_val = 32'h0;
    logic        addr_wide = 1'b0;
    logic        cond_valid, take_branch;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    brcc_eval u_brcc_eval (
        .op_lead(op_lead), .op_ext(op_ext),
        .flag_cf(flag_cf), .flag_zf(flag_zf), .flag_sf(flag_sf),
        .flag_of(flag_of), .flag_pf(flag_pf),
        .count_val(count_val), .addr_wide(addr_wide),
        .cond_valid(cond_valid), .take_branch(take_branch)
    );

    // Behavioural reference built from the requirement text.
    function automatic void model(input int lead, input int ext, input int fl,
                                  input longint cnt, input bit wide,
                                  output bit v, output bit t);
        bit c, z, s, o, p;
        int cc;
        c = fl[4]; z = fl[3]; s = fl[2]; o = fl[1]; p = fl[0];
        v = 0; t = 0; cc = -1;
        if (lead >= 'h70 && lead <= 'h7F) cc = lead - 'h70;
        else if (lead == 'h0F && ext >= 'h80 && ext <= 'h8F) cc = ext - 'h80;
        if (cc >= 0) begin
            v = 1;
            case (cc / 2)
                0: t = (o == 1);
                1: t = (c == 1);
                2: t = (z == 1);
                3: t = (c == 1) || (z == 1);
                4: t = (s == 1);
                5: t = (p == 1);
                6: t = (s != o);
                default: t = (z == 1) || (s != o);
            endcase
            if (cc % 2 == 1) t = !t;
        end else if (lead == 'hE3) begin
            v = 1;
            if (wide) t = (cnt == 0);
            else      t = ((cnt % 65536) == 0);
        end
    endfunction

    task automatic apply(input int lead, input int ext, input int fl,
                         input longint cnt, input bit wide, input string tag);
        bit ev, et;
        @(posedge clk);
        op_lead = 8'(lead); op_ext = 8'(ext);
        {flag_cf, flag_zf, flag_sf, flag_of, flag_pf} = 5'(fl);
        count_val = 32'(cnt); addr_wide = wide;
        model(lead, ext, fl, cnt, wide, ev, et);
        @(negedge clk);
        n_tests++;
        if (cond_valid !== ev || take_branch !== et) begin
            n_fail++;
            $display("FAIL %s lead=%02h ext=%02h fl=%05b cnt=%08h wide=%0d got v/t=%0b%0b exp=%0b%0b",
                     tag, lead, ext, fl, cnt, wide, cond_valid, take_branch, ev, et);
        end
    endtask

    function automatic string tag_for(input int cc);
        if (cc < 6)  return "R3";
        if (cc < 8)  return "R4";
        if (cc < 12) return "R5";
        return "R6";
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: idle inputs (lead 00h) give no valid branch (R1)
        apply(0, 0, 0, 0, 0, "R1");

        // Short forms, all flags, varied following byte (R3..R6, R8)
        for (int cc = 0; cc < 16; cc++)
            for (int fl = 0; fl < 32; fl++)
                apply('h70 + cc, (fl * 37 + cc) % 256, fl, 0, 0, tag_for(cc));
        for (int e = 0; e < 256; e += 17)
            apply('h7E, e, 5'b00110, 0, 1, "R8");

        // Near forms (R7)
        for (int cc = 0; cc < 16; cc++)
            for (int fl = 0; fl < 32; fl++)
                apply('h0F, 'h80 + cc, fl, 0, 0, "R7");

        // Pair inversion at the ports (R2)
        for (int cc = 0; cc < 16; cc += 2)
            for (int fl = 0; fl < 32; fl += 3) begin
                bit a;
                apply('h70 + cc, 0, fl, 0, 0, "R2");
                a = take_branch;
                apply('h71 + cc, 0, fl, 0, 0, "R2");
                n_tests++;
                if (a === take_branch) begin
                    n_fail++;
                    $display("FAIL R2 code %0h got both=%0b expected opposite", cc, a);
                end
            end

        // Unrecognised leads and escape with wrong second byte (R1, R12)
        for (int l = 0; l < 256; l++)
            apply(l, 'h85, 5'b11111, 0, 0, "R12");
        for (int e = 0; e < 256; e++)
            apply('h0F, e, 5'b01010, 0, 1, "R1");

        // Count test (R9, R10, R11)
        for (int fl = 0; fl < 32; fl += 5) begin
            apply('hE3, 0, fl, 32'h0000_0000, 0, "R11");
            apply('hE3, 0, fl, 32'h0000_0001, 1, "R11");
        end
        apply('hE3, 0, 0, 32'h0001_0000, 0, "R9");
        apply('hE3, 0, 0, 32'hFFFF_0000, 0, "R9");
        apply('hE3, 0, 0, 32'h0000_FFFF, 0, "R9");
        apply('hE3, 0, 0, 32'h0000_8000, 0, "R9");
        apply('hE3, 0, 0, 32'h0001_0000, 1, "R10");
        apply('hE3, 0, 0, 32'h8000_0000, 1, "R10");
        apply('hE3, 0, 0, 32'h0000_0000, 1, "R10");
        apply('hE3, 0, 0, 32'h0000_0001, 1, "R10");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired got running expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule